// File: doc/BRIEF.md
# Registered Pin Streamer with Edge-Aligned Capture

This block sits between a stream-driven protocol engine and a group of general-purpose pins. The engine sends a stream of transfers. Each transfer carries the next drive values for the pins, their output enables, a flag asking for a capture of the pins, and a metadata word of its own. Each accepted transfer loads the output flip-flops. On that same internal clock edge the input flip-flops sample the pins. The pins are therefore captured as they stood before the new drive reaches the board.

Transfers whose sample flag is set produce one item on the return stream, one clock cycle after acceptance. The item pairs the captured pin values with that transfer's metadata. The engine can toggle a serial clock pin on every cycle and still know that each item shows the pins at the outside edge that its own transfer launched.

The transfer stream uses valid/ready. A transfer is accepted on a rising clock edge where both `tx_valid` and `tx_ready` are high. Ready is low during reset and rises on the first clock edge after reset is released. From then on it stays high, so the engine never waits. The return stream has no ready: its consumer must take every item in the cycle it is offered. Reset is synchronous and active low.

Top module: `pin_streamer`

## Requirements
- R1: While `rst_n` is low, each clock edge clears `pad_out` and `pad_oe` to all zeros and drops `rx_valid` and `tx_ready` to 0.
- R2: `tx_ready` is 1 on every cycle that follows a clock edge at which `rst_n` was already high on the previous edge.
- R3: On an accepting edge, `pad_out` and `pad_oe` take the values of `tx_out` and `tx_oe`, and they show them from that edge on.
- R4: On an edge without acceptance, `pad_out` and `pad_oe` keep their values.
- R5: When an accepted transfer has `tx_sample` = 1, `rx_valid` is 1 for the cycle after that edge. `rx_data` then equals the value `pad_in` had just before that edge, not the value after the new drive.
- R6: The `rx_meta` of that item equals the `tx_meta` of the transfer that caused it.
- R7: An accepted transfer with `tx_sample` = 0, or a cycle without acceptance, leaves `rx_valid` at 0 in the following cycle.
- R8: Transfers accepted on consecutive edges each give their own item on consecutive cycles, with no loss or merging.
- R9: A transfer presented on an edge where `rst_n` is low is not accepted. It yields no item, and `pad_oe` stays all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_valid | input | 1 | Transfer present |
| tx_ready | output | 1 | Transfer can be accepted |
| tx_out | input | PINS | Next pin drive values |
| tx_oe | input | PINS | Next pin output enables |
| tx_sample | input | 1 | Return a capture for this transfer |
| tx_meta | input | META_W | Opaque tag returned with the capture |
| pad_out | output | PINS | Registered drive to the pins |
| pad_oe | output | PINS | Registered output enables to the pins |
| pad_in | input | PINS | Pin levels seen from outside |
| rx_valid | output | 1 | Capture item present, one cycle wide |
| rx_data | output | PINS | Captured pin levels |
| rx_meta | output | META_W | Tag of the transfer that caused the capture |

## Verification
The hardest case to reach is the one where the captured pins differ from the drive that the same transfer launches. Only that case tells an edge-aligned capture apart from one taken a cycle late. The bench closes the loop with a delayed model of the pins: each enabled bit reads back its own drive, and each disabled bit reads a pattern from the bench. It then sweeps all drive and enable combinations back to back, so every sample must show the previous transfer's drive. Gaps without a valid transfer, and transfers with the sample flag clear, are mixed into the sweep so that hold and no-item behaviour are checked between the items.

// File: rtl/pin_streamer_pkg.sv
package pin_streamer_pkg;
  // Cycles from an accepting edge to the returned item.
  localparam int unsigned PS_RETURN_LATENCY = 1;

  // Level a pin shows when its own drive is enabled, else the outside level.
  function automatic logic pin_level(input logic drv, input logic en, input logic ext);
    return en ? drv : ext;
  endfunction
endpackage

// File: rtl/ps_ready_gen.sv
module ps_ready_gen (
  input  logic clk,
  input  logic rst_n,
  output logic ready
);
  logic ready_q;
  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign ready = ready_q;
endmodule

// File: rtl/ps_out_stage.sv
module ps_out_stage #(
  parameter int unsigned PINS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [PINS-1:0] drv_d,
  input  logic [PINS-1:0] en_d,
  output logic [PINS-1:0] drv_q,
  output logic [PINS-1:0] en_q
);
  logic [PINS-1:0] drv_r;
  logic [PINS-1:0] en_r;

  // One output flop pair per pin, each placed next to its pad.
  for (genvar p = 0; p < PINS; p++) begin : g_pin
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        drv_r[p] <= 1'b0;
        en_r[p]  <= 1'b0;
      end else if (load) begin
        drv_r[p] <= drv_d[p];
        en_r[p]  <= en_d[p];
      end
    end
  end

  assign drv_q = drv_r;
  assign en_q  = en_r;
endmodule

// File: rtl/ps_in_stage.sv
module ps_in_stage #(
  parameter int unsigned PINS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [PINS-1:0] pins,
  output logic [PINS-1:0] cap
);
  logic [PINS-1:0] cap_r;

  // The capture flop fires on the same edge that loads the drive flops,
  // so it holds the pin levels from before the new drive.
  always_ff @(posedge clk) begin
    if (!rst_n)    cap_r <= '0;
    else if (take) cap_r <= pins;
  end

  assign cap = cap_r;
endmodule

// File: rtl/ps_tag_pipe.sv
module ps_tag_pipe #(
  parameter int unsigned META_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [META_W-1:0] tag_d,
  output logic              vld_q,
  output logic [META_W-1:0] tag_q
);
  logic              vld_r;
  logic [META_W-1:0] tag_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_r <= 1'b0;
      tag_r <= '0;
    end else begin
      vld_r <= fire;
      if (fire) tag_r <= tag_d;
    end
  end

  assign vld_q = vld_r;
  assign tag_q = tag_r;
endmodule

// File: rtl/pin_streamer.sv
module pin_streamer #(
  parameter int unsigned PINS   = 4,
  parameter int unsigned META_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [PINS-1:0]   tx_out,
  input  logic [PINS-1:0]   tx_oe,
  input  logic              tx_sample,
  input  logic [META_W-1:0] tx_meta,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  input  logic [PINS-1:0]   pad_in,
  output logic              rx_valid,
  output logic [PINS-1:0]   rx_data,
  output logic [META_W-1:0] rx_meta
);
  logic accept;
  logic want_cap;

  assign accept   = tx_valid & tx_ready;
  assign want_cap = accept & tx_sample;

  ps_ready_gen u_ready (
    .clk   (clk),
    .rst_n (rst_n),
    .ready (tx_ready)
  );

  ps_out_stage #(.PINS(PINS)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .drv_d (tx_out),
    .en_d  (tx_oe),
    .drv_q (pad_out),
    .en_q  (pad_oe)
  );

  ps_in_stage #(.PINS(PINS)) u_in (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (want_cap),
    .pins  (pad_in),
    .cap   (rx_data)
  );

  ps_tag_pipe #(.META_W(META_W)) u_tag (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (want_cap),
    .tag_d (tx_meta),
    .vld_q (rx_valid),
    .tag_q (rx_meta)
  );
endmodule

// File: rtl/pin_streamer_chk.sv
module pin_streamer_chk #(
  parameter int unsigned PINS   = 4,
  parameter int unsigned META_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [PINS-1:0]   tx_out,
  input logic [PINS-1:0]   tx_oe,
  input logic              tx_sample,
  input logic [META_W-1:0] tx_meta,
  input logic [PINS-1:0]   pad_out,
  input logic [PINS-1:0]   pad_oe,
  input logic [PINS-1:0]   pad_in,
  input logic              rx_valid,
  input logic [PINS-1:0]   rx_data,
  input logic [META_W-1:0] rx_meta
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (pad_oe == '0 && pad_out == '0 && !rx_valid && !tx_ready));

  // R2
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> tx_ready);

  // R3
  drive_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (pad_out == $past(tx_out) && pad_oe == $past(tx_oe)));

  // R4
  drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && tx_ready) |=> ($stable(pad_out) && $stable(pad_oe)));

  // R5
  capture_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_sample) |=> (rx_valid && rx_data == $past(pad_in)));

  // R6
  meta_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_sample) |=> (rx_meta == $past(tx_meta)));

  // R7
  no_item_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && tx_ready && tx_sample) |=> !rx_valid);
endmodule

bind pin_streamer pin_streamer_chk #(.PINS(PINS), .META_W(META_W)) u_chk (.*);

// File: tb/pin_streamer_tb.sv
module pin_streamer_tb;
  import pin_streamer_pkg::*;

  localparam int unsigned PINS   = 4;
  localparam int unsigned META_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tx_valid = 1'b0;
  logic              tx_ready;
  logic [PINS-1:0]   tx_out = '0;
  logic [PINS-1:0]   tx_oe = '0;
  logic              tx_sample = 1'b0;
  logic [META_W-1:0] tx_meta = '0;
  logic [PINS-1:0]   pad_out;
  logic [PINS-1:0]   pad_oe;
  logic [PINS-1:0]   pad_in;
  logic [PINS-1:0]   ext = '0;
  logic              rx_valid;
  logic [PINS-1:0]   rx_data;
  logic [META_W-1:0] rx_meta;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  // Delayed loopback: enabled pins read back their own drive, the rest read ext.
  assign #3 pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  pin_streamer #(.PINS(PINS), .META_W(META_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_out(tx_out), .tx_oe(tx_oe),
    .tx_sample(tx_sample), .tx_meta(tx_meta),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_meta(rx_meta)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  logic [PINS-1:0] m_out = '0;
  logic [PINS-1:0] m_oe  = '0;
  logic [PINS-1:0] m_pin;
  int prev_item_step = -10;

  initial begin : watchdog
    #1500000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    check(pad_out == '0, "R1 pad_out", 32'(pad_out), 0);
    check(pad_oe == '0, "R1 pad_oe", 32'(pad_oe), 0);
    check(!rx_valid, "R1 rx_valid", 32'(rx_valid), 0);
    check(!tx_ready, "R1 tx_ready", 32'(tx_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 ready rises after first edge out of reset
    check(tx_ready, "R2 tx_ready", 32'(tx_ready), 1);

    for (int i = 0; i < 600; i++) begin
      logic v, s, acc;
      logic [PINS-1:0] o, e;
      logic [META_W-1:0] mt;
      v  = (i % 7) != 3;
      o  = PINS'(i);
      e  = PINS'(i >> 4);
      s  = ((i % 5) != 2);
      mt = META_W'(i * 37 + 11);
      ext = PINS'(i * 5 + 3);
      tx_valid = v; tx_out = o; tx_oe = e; tx_sample = s; tx_meta = mt;
      // Pin levels just before the coming edge.
      for (int b = 0; b < PINS; b++) m_pin[b] = pin_level(m_out[b], m_oe[b], ext[b]);
      check(tx_ready, "R2 ready", 32'(tx_ready), 1);
      acc = v;
      @(posedge clk);
      @(negedge clk);
      if (acc) begin m_out = o; m_oe = e; end
      // R3 / R4 registered drive
      check(pad_out == m_out, acc ? "R3 pad_out" : "R4 pad_out", 32'(pad_out), 32'(m_out));
      check(pad_oe == m_oe, acc ? "R3 pad_oe" : "R4 pad_oe", 32'(pad_oe), 32'(m_oe));
      if (acc && s) begin
        check(rx_valid, "R5 rx_valid", 32'(rx_valid), 1);
        check(rx_data == m_pin, "R5 rx_data", 32'(rx_data), 32'(m_pin));
        check(rx_meta == mt, "R6 rx_meta", 32'(rx_meta), 32'(mt));
        // R8 back-to-back items each arrive
        if (prev_item_step == i - 1)
          check(rx_valid && rx_meta == mt, "R8 consecutive", 32'(rx_meta), 32'(mt));
        prev_item_step = i;
      end else begin
        check(!rx_valid, "R7 rx_valid", 32'(rx_valid), 0);
      end
    end

    // R9 transfer during reset is dropped
    tx_valid = 1'b1; tx_sample = 1'b1; tx_oe = '1; tx_out = '1; tx_meta = 8'h5A;
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(!rx_valid, "R9 rx_valid", 32'(rx_valid), 0);
    check(pad_oe == '0, "R9 pad_oe", 32'(pad_oe), 0);
    @(posedge clk);
    @(negedge clk);
    check(!rx_valid, "R9 rx_valid hold", 32'(rx_valid), 0);
    check(pad_oe == '0, "R9 pad_oe hold", 32'(pad_oe), 0);
    tx_valid = 1'b0;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule